// File: doc/BRIEF.md
# Serial Port Interrupt Identification Controller

This block sits beside the receiver, transmitter and FIFOs of a 16550-style serial port. It collects their event strobes, keeps one pending flag per interrupt source, and presents those flags to the host in two views. In legacy view, the identification register holds a single 4-bit code for the highest-priority event that is both pending and enabled. In extended view, it holds one raw flag per source, whatever the enable mask says.

Each flag clears on its own host access. Line errors clear on a read of line status. Modem changes clear on a read of modem status. The transmit-low flag clears on a write of transmit data, or on a read of the identification register while it is the reported top event. Receive-data pending follows the FIFO level. The receive timeout clears on a read of receive data. A character-period tick drives a 4-character receive timeout. In FIFO mode, parity, framing and break errors are taken when the affected character reaches the head of the FIFO, while overrun is taken at once. The interrupt request is the OR of the enabled pending sources.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with FIFOs off and no event, the identification output reads 01h and irq_o is low.
- R2: In legacy view, id_o[3:0] reports the top event among enabled sources. Priority and codes are: line status 0110, receive data 0100, receive timeout 1100, transmit low 0010, modem 0000. The code is 0001 when no enabled source is pending.
- R3: The line flag is set by an overrun strobe. A read of line status clears it, and the clear is visible on the cycle after the read.
- R4: With FIFOs off, an error strobe on a received character sets the line flag and the head-of-FIFO error strobe is ignored. With FIFOs on, only the head-of-FIFO error strobe sets it.
- R5: Receive data is pending while the level is at or above the threshold (FIFOs on) or nonzero (FIFOs off). It stops being pending as soon as the level drops below that.
- R6: With FIFOs on and data held, the timeout flag sets on the 4th character tick with no push or pop in between. A push or pop restarts the count, a read of receive data clears the flag, and an empty FIFO keeps it clear.
- R7: The transmit-low flag sets when the transmit condition becomes true: level below threshold with FIFOs on, level zero with FIFOs off. A write of transmit data clears it.
- R8: A read of the identification register clears the transmit-low flag only when transmit low is the reported code. Otherwise the flag is kept.
- R9: The modem flag sets on any edge of cts_i, dsr_i or dcd_i and on a rising edge of ri_i. A falling edge of ri_i alone does not set it. A read of modem status clears it.
- R10: In extended view, id_o bit0 is receive data or timeout, bit1 is transmit low, bit2 is line status, bit3 is modem, bit5 is tx_empty_i, and bits 4, 6 and 7 are 0.
- R11: Extended-view flags show regardless of the enable mask.
- R12: irq_o is the OR of the pending sources gated by ier_i (bit0 receive data and timeout, bit1 transmit low, bit2 line, bit3 modem). It is low when ier_i is zero.
- R13: In legacy view, id_o[7:6] read 11 when FIFOs are on and 00 when they are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the extended per-flag view |
| fifo_en_i | input | 1 | FIFOs enabled |
| ier_i | input | 4 | Interrupt enable mask |
| overrun_i | input | 1 | Receive overrun strobe |
| rx_push_err_i | input | 1 | Errored character received (used with FIFOs off) |
| rx_head_err_i | input | 1 | Errored character at FIFO head (used with FIFOs on) |
| rx_push_i | input | 1 | Receive FIFO push |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_thresh_i | input | LVL_W | Receive threshold |
| char_tick_i | input | 1 | One pulse per character time |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit low threshold |
| tx_empty_i | input | 1 | Transmitter fully empty |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| dcd_i | input | 1 | Carrier-detect line |
| ri_i | input | 1 | Ring indicator line |
| rd_lsr_i | input | 1 | Line status read strobe |
| rd_rxd_i | input | 1 | Receive data read strobe (FIFO pop) |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_msr_i | input | 1 | Modem status read strobe |
| wr_txd_i | input | 1 | Transmit data write strobe |
| id_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker checks on every cycle that the legacy code and irq_o agree on whether anything is pending, and that a zero mask keeps irq_o low. It also checks that a line status read clears the line flag, that an empty FIFO clears the timeout, that a lone falling ring edge leaves the modem flag alone, and that the reserved extended bits stay 0. The bench's scenarios are what show the rest: the full priority order, the deferral of errors to the FIFO head, the exact tick count and the restart of the timeout, and the conditional clear of transmit low on an identification read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_NONE   = 4'b0001,
    ID_LINE   = 4'b0110,
    ID_RXDATA = 4'b0100,
    ID_RXTO   = 4'b1100,
    ID_TXLOW  = 4'b0010,
    ID_MODEM  = 4'b0000
  } id_code_e;

  typedef struct packed {
    logic modem;
    logic txlow;
    logic line;
    logic rxto;
    logic rxdata;
  } src_t;

  localparam int unsigned N_FLAGS = 3;  // line, txlow, modem
endpackage

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             tick_i,
  output logic             to_o
);
  localparam int unsigned CW = $clog2(TO_CHARS + 1);

  logic [CW-1:0] cnt_q;
  logic          to_q;
  logic          idle_empty, restart, fire;

  assign idle_empty = !fifo_en_i || (level_i == '0);
  assign restart    = idle_empty || push_i || pop_i;
  assign fire       = !restart && tick_i && (cnt_q == CW'(TO_CHARS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (restart)                            cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(TO_CHARS))   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     to_q <= 1'b0;
    else if (fire)                   to_q <= 1'b1;
    else if (pop_i || idle_empty)    to_q <= 1'b0;
  end

  assign to_o = to_q;
endmodule

// File: rtl/uart_irq_modem_edge.sv
module uart_irq_modem_edge #(
  parameter int unsigned         N_LINES   = 4,
  parameter logic [N_LINES-1:0]  RISE_ONLY = 4'b1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic               change_o
);
  logic [N_LINES-1:0] line_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_i;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (RISE_ONLY[g]) begin : g_rise
      assign hit[g] = line_i[g] & ~line_q[g];
    end else begin : g_any
      assign hit[g] = line_i[g] ^ line_q[g];
    end
  end

  assign change_o = |hit;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_t     pend_i,
  output id_code_e code_o
);
  always_comb begin
    if (pend_i.line)        code_o = ID_LINE;
    else if (pend_i.rxdata) code_o = ID_RXDATA;
    else if (pend_i.rxto)   code_o = ID_RXTO;
    else if (pend_i.txlow)  code_o = ID_TXLOW;
    else if (pend_i.modem)  code_o = ID_MODEM;
    else                    code_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             fifo_en_i,
  input  logic [3:0]       ier_i,
  input  logic             overrun_i,
  input  logic             rx_push_err_i,
  input  logic             rx_head_err_i,
  input  logic             rx_push_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_thresh_i,
  input  logic             char_tick_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_thresh_i,
  input  logic             tx_empty_i,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             dcd_i,
  input  logic             ri_i,
  input  logic             rd_lsr_i,
  input  logic             rd_rxd_i,
  input  logic             rd_iir_i,
  input  logic             rd_msr_i,
  input  logic             wr_txd_i,
  output logic [7:0]       id_o,
  output logic             irq_o
);
  localparam int unsigned F_LINE  = 0;
  localparam int unsigned F_TX    = 1;
  localparam int unsigned F_MODEM = 2;

  logic                rx_cond, tx_cond, tx_cond_q;
  logic                to_q, ms_change;
  logic [N_FLAGS-1:0]  set_vec, clr_vec, flag_q;
  logic                ls_q, tx_q, ms_q;
  src_t                en_pend;
  id_code_e            code;

  assign rx_cond = fifo_en_i ? (rx_level_i >= rx_thresh_i && rx_level_i != '0)
                             : (rx_level_i != '0);
  assign tx_cond = fifo_en_i ? (tx_level_i < tx_thresh_i) : (tx_level_i == '0);

  // reset to 1: an idle transmitter raises no event until it refills and drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_cond_q <= 1'b1;
    else         tx_cond_q <= tx_cond;
  end

  uart_irq_rx_timeout #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) i_rx_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fifo_en_i(fifo_en_i),
    .level_i  (rx_level_i),
    .push_i   (rx_push_i),
    .pop_i    (rd_rxd_i),
    .tick_i   (char_tick_i),
    .to_o     (to_q)
  );

  uart_irq_modem_edge #(.N_LINES(4), .RISE_ONLY(4'b1000)) i_modem_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  ({ri_i, dcd_i, dsr_i, cts_i}),
    .change_o(ms_change)
  );

  assign set_vec[F_LINE]  = overrun_i | (fifo_en_i ? rx_head_err_i : rx_push_err_i);
  assign set_vec[F_TX]    = tx_cond & ~tx_cond_q;
  assign set_vec[F_MODEM] = ms_change;

  assign clr_vec[F_LINE]  = rd_lsr_i;
  assign clr_vec[F_TX]    = wr_txd_i | (rd_iir_i && code == ID_TXLOW);
  assign clr_vec[F_MODEM] = rd_msr_i;

  // a new event on the clear edge is kept
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[g] <= 1'b0;
      else if (set_vec[g]) flag_q[g] <= 1'b1;
      else if (clr_vec[g]) flag_q[g] <= 1'b0;
    end
  end

  assign ls_q = flag_q[F_LINE];
  assign tx_q = flag_q[F_TX];
  assign ms_q = flag_q[F_MODEM];

  assign en_pend.line   = ls_q    & ier_i[2];
  assign en_pend.rxdata = rx_cond & ier_i[0];
  assign en_pend.rxto   = to_q    & ier_i[0];
  assign en_pend.txlow  = tx_q    & ier_i[1];
  assign en_pend.modem  = ms_q    & ier_i[3];

  uart_irq_prio i_prio (
    .pend_i(en_pend),
    .code_o(code)
  );

  always_comb begin
    if (ext_mode_i) id_o = {2'b00, tx_empty_i, 1'b0, ms_q, ls_q, tx_q, rx_cond | to_q};
    else            id_o = {{2{fifo_en_i}}, 2'b00, code};
  end

  assign irq_o = |en_pend;
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_mode_i,
  input logic [3:0]       ier_i,
  input logic             overrun_i,
  input logic             rx_push_err_i,
  input logic             rx_head_err_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             cts_i,
  input logic             dsr_i,
  input logic             dcd_i,
  input logic             ri_i,
  input logic             rd_lsr_i,
  input logic [7:0]       id_o,
  input logic             irq_o,
  input logic             ls_q,
  input logic             ms_q,
  input logic             to_q
);
  assert_irq_matches_id_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (irq_o == !id_o[0]));

  assert_masked_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 4'h0) |-> !irq_o);

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (id_o[3:0] inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000}));

  assert_ls_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr_i && !overrun_i && !rx_push_err_i && !rx_head_err_i) |=> !ls_q);

  assert_empty_no_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |=> !to_q);

  assert_ri_fall_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ri_i) && $stable(cts_i) && $stable(dsr_i) && $stable(dcd_i) && !ms_q) |=> !ms_q);

  assert_ext_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |-> (id_o[7:6] == 2'b00 && !id_o[4]));
endmodule

bind uart_irq_ident uart_irq_checker #(.LVL_W(LVL_W)) i_uart_irq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ext_mode_i   (ext_mode_i),
  .ier_i        (ier_i),
  .overrun_i    (overrun_i),
  .rx_push_err_i(rx_push_err_i),
  .rx_head_err_i(rx_head_err_i),
  .rx_level_i   (rx_level_i),
  .cts_i        (cts_i),
  .dsr_i        (dsr_i),
  .dcd_i        (dcd_i),
  .ri_i         (ri_i),
  .rd_lsr_i     (rd_lsr_i),
  .id_o         (id_o),
  .irq_o        (irq_o),
  .ls_q         (ls_q),
  .ms_q         (ms_q),
  .to_q         (to_q)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  localparam int unsigned LVL_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_mode = 0, fifo_en = 0;
  logic [3:0] ier = 4'h0;
  logic overrun = 0, push_err = 0, head_err = 0, rx_push = 0, tick = 0;
  logic [LVL_W-1:0] rx_level = '0, rx_thresh = 5'd4, tx_level = '0, tx_thresh = 5'd2;
  logic tx_empty = 1, cts = 0, dsr = 0, dcd = 0, ri = 0;
  logic rd_lsr = 0, rd_rxd = 0, rd_iir = 0, rd_msr = 0, wr_txd = 0;
  logic [7:0] id;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] id;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W), .TO_CHARS(4)) i_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .fifo_en_i(fifo_en),
    .ier_i(ier), .overrun_i(overrun), .rx_push_err_i(push_err), .rx_head_err_i(head_err),
    .rx_push_i(rx_push), .rx_level_i(rx_level), .rx_thresh_i(rx_thresh),
    .char_tick_i(tick), .tx_level_i(tx_level), .tx_thresh_i(tx_thresh),
    .tx_empty_i(tx_empty), .cts_i(cts), .dsr_i(dsr), .dcd_i(dcd), .ri_i(ri),
    .rd_lsr_i(rd_lsr), .rd_rxd_i(rd_rxd), .rd_iir_i(rd_iir), .rd_msr_i(rd_msr),
    .wr_txd_i(wr_txd), .id_o(id), .irq_o(irq)
  );

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (id !== e.id || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b", e.tag, id, irq, e.id, e.irq);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [7:0] eid, input logic eirq, input string tag);
    exp_t e;
    e.id = eid; e.irq = eirq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic tick_once();
    tick = 1; step(); tick = 0; step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    expect_out(8'h01, 0, "R1 reset state");

    ier = 4'hF; step();
    expect_out(8'h01, 0, "R12 nothing pending");

    overrun = 1; step(); overrun = 0;
    expect_out(8'h06, 1, "R3 overrun sets line");
    rd_lsr = 1; step(); rd_lsr = 0;
    expect_out(8'h01, 0, "R3 lsr read clears");

    push_err = 1; step(); push_err = 0;
    expect_out(8'h06, 1, "R4 fifo off error immediate");
    rd_lsr = 1; step(); rd_lsr = 0;
    expect_out(8'h01, 0, "R3 clear again");

    fifo_en = 1; step();
    expect_out(8'hC1, 0, "R13 fifo bits");
    push_err = 1; step(); push_err = 0;
    expect_out(8'hC1, 0, "R4 push error ignored in fifo mode");
    head_err = 1; step(); head_err = 0;
    expect_out(8'hC6, 1, "R4 head error reported");
    rd_lsr = 1; step(); rd_lsr = 0;
    expect_out(8'hC1, 0, "R3 clear in fifo mode");

    rx_level = 5'd3; step();
    expect_out(8'hC1, 0, "R5 below threshold");
    rx_level = 5'd4; step();
    expect_out(8'hC4, 1, "R5 at threshold");
    rx_level = 5'd3; step();
    expect_out(8'hC1, 0, "R5 drops below threshold");
    rx_level = 5'd0; step();

    fifo_en = 0; rx_level = 5'd1; step();
    expect_out(8'h04, 1, "R5 holding register full");
    rx_level = 5'd0; step();
    expect_out(8'h01, 0, "R5 holding register empty");

    fifo_en = 1; rx_level = 5'd2; rx_push = 1; step(); rx_push = 0;
    for (int i = 0; i < 3; i++) tick_once();
    expect_out(8'hC1, 0, "R6 three ticks no timeout");
    rx_push = 1; step(); rx_push = 0;
    for (int i = 0; i < 3; i++) tick_once();
    expect_out(8'hC1, 0, "R6 push restarts count");
    tick = 1; step(); tick = 0;
    expect_out(8'hCC, 1, "R6 timeout on fourth tick");
    rd_rxd = 1; step(); rd_rxd = 0;
    expect_out(8'hC1, 0, "R6 data read clears timeout");
    rx_level = 5'd0; step();

    fifo_en = 0; step();
    tx_level = 5'd1; step();
    tx_level = 5'd0; step();
    expect_out(8'h02, 1, "R7 holding register empties");
    wr_txd = 1; step(); wr_txd = 0;
    expect_out(8'h01, 0, "R7 write clears");

    tx_level = 5'd1; step(); tx_level = 5'd0; step();
    cts = 1; step();
    expect_out(8'h02, 1, "R8 tx over modem");
    rd_iir = 1; step(); rd_iir = 0;
    expect_out(8'h00, 1, "R8 id read clears top tx");
    rd_msr = 1; step(); rd_msr = 0;
    expect_out(8'h01, 0, "R9 msr read clears");

    tx_level = 5'd1; step(); tx_level = 5'd0; step();
    overrun = 1; step(); overrun = 0;
    expect_out(8'h06, 1, "R2 line over tx");
    rd_iir = 1; step(); rd_iir = 0;
    expect_out(8'h06, 1, "R8 id read with line on top");
    rd_lsr = 1; step(); rd_lsr = 0;
    expect_out(8'h02, 1, "R8 tx kept when not top");
    wr_txd = 1; step(); wr_txd = 0;
    expect_out(8'h01, 0, "R7 write clears");

    ri = 1; step();
    expect_out(8'h00, 1, "R9 ri rising");
    rd_msr = 1; step(); rd_msr = 0;
    expect_out(8'h01, 0, "R9 clear");
    ri = 0; step();
    expect_out(8'h01, 0, "R9 ri falling ignored");
    dsr = 1; step();
    expect_out(8'h00, 1, "R9 dsr edge");
    rd_msr = 1; step(); rd_msr = 0;
    expect_out(8'h01, 0, "R9 clear");

    ier = 4'b1000;
    overrun = 1; step(); overrun = 0;
    expect_out(8'h01, 0, "R2 disabled source not reported");
    ext_mode = 1; step();
    expect_out(8'h24, 0, "R11 flag shown while masked");
    ier = 4'hF; step();
    expect_out(8'h24, 1, "R12 enabled line raises irq");
    dcd = 1; step();
    expect_out(8'h2C, 1, "R10 modem bit3");
    tx_level = 5'd1; step(); tx_level = 5'd0; step();
    expect_out(8'h2E, 1, "R10 tx bit1");
    tx_empty = 0; rx_level = 5'd1; step();
    expect_out(8'h0F, 1, "R10 rx bit0 and bit5 follows input");
    rd_lsr = 1; rd_msr = 1; wr_txd = 1; step();
    rd_lsr = 0; rd_msr = 0; wr_txd = 0;
    expect_out(8'h01, 1, "R10 flags cleared by accesses");
    rx_level = 5'd0; step();
    expect_out(8'h00, 0, "R10 all clear");

    done = 1;
    step();
    finish_run();
  end
endmodule